// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip word scratchpad spread over several single-ported banks and shared by a group of lanes that issue one access together. Every lane has its own enable, word address, direction and write word. The low bits of a word address pick the bank and the remaining bits pick the row inside that bank. Any access pattern whose lanes all fall in different banks, or that only repeats one address, finishes in one pass.

When lanes hit one bank at different rows, the block breaks the access into several passes. In each pass every bank serves one row. For each bank, the lowest-numbered lane still waiting picks the row. Every waiting lane that names that same address is served with it: reads share one broadcast word and writes merge. Once no lane is left waiting, the block returns all read words at once, reports the pass count and flags a serialized access. Conflicts are only counted inside one access.

The control is a three-state machine. `ST_IDLE` accepts a request. It goes to `ST_PASS` when at least one lane is enabled, and to `ST_DONE` when none is. `ST_PASS` serves one pass per cycle and stays in `ST_PASS` while lanes are still waiting. It moves to `ST_DONE` once the last waiting lane is served. `ST_DONE` holds for one cycle and always returns to `ST_IDLE`.

Top module: `spad_conflict_serializer`

## Requirements
- R1: The bank of a word is address bits [3:0] (address modulo 16) and its row is address bits [7:4]; a word written at any address reads back unchanged from that address.
- R2: An access whose enabled lanes all fall in different banks, including stride-1 and any one-to-one bank permutation, finishes in 1 pass with `serialize` low.
- R3: All sixteen lanes reading one address finish in 1 pass and each receives the same stored word.
- R4: The pass count equals the largest number of distinct addresses aimed at one bank: stride 2 gives 2, stride 8 gives 8, stride 16 gives 16, stride 17 (a padded tile column) gives 1. `serialize` is high with `done` exactly when the count exceeds 1.
- R5: Lanes that share an address inside a bank are served in the same pass, so two groups of lanes on two rows of one bank take exactly 2 passes.
- R6: When several enabled lanes write one address in the same access, the word from the highest-numbered of those lanes is stored.
- R7: A lane whose enable is low writes nothing, adds no pass, and its `rd_data` slice reads zero.
- R8: `done` is a one-cycle pulse seen N+1 cycles after the accepting edge for an N-pass access. `ready` is high only in `ST_IDLE`, and a request offered while the block is busy is ignored.
- R9: An access with no enabled lane goes straight to `ST_DONE` with a pass count of 0 and `serialize` low.
- R10: After reset `ready` is high, and `done`, `serialize` and `pass_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Offers an access; taken only while `ready` is high |
| req_act | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| req_we | input | LANES | Per-lane write (1) or read (0) |
| req_wdata | input | LANES*DW | Per-lane write word |
| ready | output | 1 | Block idle, new access may be offered |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES*DW | Per-lane read word, valid with `done` |
| pass_cnt | output | $clog2(LANES+1) | Passes used by the finished access |
| serialize | output | 1 | Access needed more than one pass, valid with `done` |

## Verification
The checker assumes requests arrive as single-cycle `req_valid` strobes. It also assumes the lane fields are stable on the accepting edge and that nothing offered while `ready` is low takes effect. The pass-count property assumes every busy cycle other than `ST_DONE` is one served pass. The bench drives every request at the falling edge for exactly one cycle and waits for `done` before it offers the next. It also deliberately offers one request while the block is busy, to show that the block refuses it. Read checks are done only on words the bench wrote earlier, and no access mixes reads and writes of the same address.

// File: rtl/spad_pkg.sv
package spad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DONE = 2'd2
    } spad_state_e;
endpackage

// File: rtl/spad_bank_pick.sv
// Per-bank pass arbiter: picks the row served this pass and the lanes that ride on it.
module spad_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int BANK_W  = 4,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr,
    input  logic [LANES-1:0]    we,
    input  logic [LANES*DW-1:0] wdata,
    output logic                hit,
    output logic [AW-BANK_W-1:0] row,
    output logic [LANES-1:0]    serve,
    output logic                wr_en,
    output logic [DW-1:0]       wr_data
);
    logic [AW-1:0] pick_addr;

    always_comb begin
        hit       = 1'b0;
        pick_addr = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!hit && pend[l] && (addr[l*AW +: BANK_W] == BANK_W'(BANK_ID))) begin
                hit       = 1'b1;
                pick_addr = addr[l*AW +: AW];
            end
        end
        row = pick_addr[AW-1:BANK_W];
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            serve[l] = hit && pend[l] && (addr[l*AW +: AW] == pick_addr);
            // ascending scan: the highest lane writing this address wins
            if (serve[l] && we[l]) begin
                wr_en   = 1'b1;
                wr_data = wdata[l*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/spad_bank_store.sv
// One single-ported bank: asynchronous read, synchronous write, same row per pass.
module spad_bank_store #(
    parameter int ROW_W = 4,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic [ROW_W-1:0] row,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_word
);
    localparam int ROWS = 1 << ROW_W;

    logic [DW-1:0] cells [ROWS];

    assign rd_word = cells[row];

    always_ff @(posedge clk) begin
        if (wr_en) cells[row] <= wr_data;
    end
endmodule

// File: rtl/spad_conflict_serializer.sv
module spad_conflict_serializer
    import spad_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [LANES-1:0]           req_act,
    input  logic [LANES*AW-1:0]        req_addr,
    input  logic [LANES-1:0]           req_we,
    input  logic [LANES*DW-1:0]        req_wdata,
    output logic                       ready,
    output logic                       done,
    output logic [LANES*DW-1:0]        rd_data,
    output logic [$clog2(LANES+1)-1:0] pass_cnt,
    output logic                       serialize
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = AW - BANK_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    spad_state_e state, state_nx;

    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    we_q;
    logic [LANES*DW-1:0] wdata_q;
    logic [LANES-1:0]    pend_q;
    logic [LANES*DW-1:0] rdata_q;
    logic [CNT_W-1:0]    cnt_q;

    logic [LANES-1:0] serve_b [BANKS];
    logic [DW-1:0]    bank_rd [BANKS];
    logic [LANES-1:0] serve_all;
    logic [LANES-1:0] pend_nx;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             hit;
        logic [ROW_W-1:0] row;
        logic             wr_en;
        logic [DW-1:0]    wr_data;

        spad_bank_pick #(
            .LANES(LANES), .AW(AW), .DW(DW), .BANK_W(BANK_W), .BANK_ID(b)
        ) u_pick (
            .pend(pend_q), .addr(addr_q), .we(we_q), .wdata(wdata_q),
            .hit(hit), .row(row), .serve(serve_b[b]),
            .wr_en(wr_en), .wr_data(wr_data)
        );

        spad_bank_store #(.ROW_W(ROW_W), .DW(DW)) u_store (
            .clk(clk), .row(row),
            .wr_en(wr_en && (state == ST_PASS)),
            .wr_data(wr_data), .rd_word(bank_rd[b])
        );
    end

    always_comb begin
        serve_all = '0;
        for (int b = 0; b < BANKS; b++) serve_all = serve_all | serve_b[b];
        pend_nx = pend_q & ~serve_all;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = (|req_act) ? ST_PASS : ST_DONE;
            ST_PASS: if (pend_nx == '0) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = (state == ST_IDLE);
        done      = (state == ST_DONE);
        serialize = (state == ST_DONE) && (cnt_q > CNT_W'(1));
        pass_cnt  = cnt_q;
        rd_data   = rdata_q;
    end

    // lane capture, pass counting and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= '0;
            wdata_q <= '0;
            pend_q  <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
            pend_q  <= req_act;
            rdata_q <= '0;
            cnt_q   <= '0;
        end else if (state == ST_PASS) begin
            pend_q <= pend_nx;
            cnt_q  <= cnt_q + CNT_W'(1);
            for (int l = 0; l < LANES; l++) begin
                if (serve_all[l] && !we_q[l])
                    rdata_q[l*DW +: DW] <= bank_rd[addr_q[l*AW +: BANK_W]];
            end
        end
    end
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
    parameter int LANES = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       ready,
    input logic                       done,
    input logic [$clog2(LANES+1)-1:0] pass_cnt,
    input logic                       serialize
);
    localparam int CNT_W = $clog2(LANES + 1);

    // independent count of busy cycles between acceptance and done
    logic [CNT_W:0] busy_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_q <= '0;
        else if (ready && req_valid) busy_q <= '0;
        else if (!ready && !done)    busy_q <= busy_q + 1'b1;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

    assert_pass_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, pass_cnt} == busy_q));

    assert_pass_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_cnt <= CNT_W'(LANES)));

    assert_serialize_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        serialize |-> done);
endmodule

bind spad_conflict_serializer spad_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
    .done(done), .pass_cnt(pass_cnt), .serialize(serialize)
);

// File: tb/sim_spad_conflict_serializer.sv
`timescale 1ns/1ps
module sim_spad_conflict_serializer;
    localparam int LANES = 16;
    localparam int AW    = 8;
    localparam int DW    = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [LANES-1:0]    req_act = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0]    req_we = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic                ready, done, serialize;
    logic [LANES*DW-1:0] rd_data;
    logic [4:0]          pass_cnt;

    spad_conflict_serializer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_act(req_act),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rd_data(rd_data),
        .pass_cnt(pass_cnt), .serialize(serialize)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] ref_mem [256];
    logic          a_act [LANES];
    logic [AW-1:0] a_addr [LANES];
    logic          a_we [LANES];
    logic [DW-1:0] a_wd [LANES];

    function automatic logic [DW-1:0] pat(input int a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0101_0301);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            a_act[l] = 1'b0; a_addr[l] = '0; a_we[l] = 1'b0; a_wd[l] = '0;
        end
    endtask

    // expected passes: most distinct addresses aimed at one bank
    function automatic int exp_passes();
        int mx = 0;
        for (int b = 0; b < 16; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                bit seen = 0;
                if (a_act[l] && a_addr[l][3:0] == 4'(b)) begin
                    for (int k = 0; k < l; k++)
                        if (a_act[k] && a_addr[k] == a_addr[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > mx) mx = cnt;
        end
        return mx;
    endfunction

    task automatic drive_req();
        for (int l = 0; l < LANES; l++) begin
            req_act[l]             = a_act[l];
            req_we[l]              = a_we[l];
            req_addr[l*AW +: AW]   = a_addr[l];
            req_wdata[l*DW +: DW]  = a_wd[l];
        end
        req_valid = 1'b1;
    endtask

    // issue, wait for done, check pass count, serialize, latency and reads
    task automatic run_access(input string req, input bit chk_data);
        int cyc;
        int ep;
        ep = exp_passes();
        @(negedge clk);
        drive_req();
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk(pass_cnt == 5'(ep), {req, " pass count"}, 32'(pass_cnt), 32'(ep));
        chk(serialize == (ep > 1), {req, " serialize"}, 32'(serialize), 32'(ep > 1));
        chk(cyc == ep + 1, {req, " R8 latency"}, 32'(cyc), 32'(ep + 1));
        if (chk_data)
            for (int l = 0; l < LANES; l++) begin
                logic [DW-1:0] e;
                e = (a_act[l] && !a_we[l]) ? ref_mem[a_addr[l]] : '0;
                chk(rd_data[l*DW +: DW] == e, {req, " read data"}, rd_data[l*DW +: DW], e);
            end
        for (int l = 0; l < LANES; l++)
            if (a_act[l] && a_we[l]) ref_mem[a_addr[l]] = a_wd[l];
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R10 ready", 32'(ready), 1);
        chk(done == 1'b0, "R10 done", 32'(done), 0);
        chk(serialize == 1'b0, "R10 serialize", 32'(serialize), 0);
        chk(pass_cnt == 5'd0, "R10 pass_cnt", 32'(pass_cnt), 0);
    endtask

    task automatic t_fill_and_read();
        for (int r = 0; r < 16; r++) begin
            clear_lanes();
            for (int l = 0; l < LANES; l++) begin
                a_act[l] = 1; a_we[l] = 1; a_addr[l] = AW'(r*16 + l); a_wd[l] = pat(r*16 + l);
            end
            run_access("R2 stride-1 write", 1'b0);
        end
        for (int r = 0; r < 16; r += 5) begin
            clear_lanes();
            for (int l = 0; l < LANES; l++) begin a_act[l] = 1; a_addr[l] = AW'(r*16 + l); end
            run_access("R1 stride-1 read", 1'b1);
        end
    endtask

    task automatic t_permute();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            a_act[l] = 1; a_addr[l] = AW'(16*l + ((7*l + 3) % 16));
        end
        run_access("R2 bank permutation", 1'b1);
    endtask

    task automatic t_broadcast();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin a_act[l] = 1; a_addr[l] = 8'd77; end
        run_access("R3 broadcast", 1'b1);
    endtask

    task automatic t_strides();
        int strides [4] = '{2, 8, 16, 17};
        foreach (strides[s]) begin
            clear_lanes();
            for (int l = 0; l < LANES; l++) begin a_act[l] = 1; a_addr[l] = AW'(l * strides[s]); end
            run_access($sformatf("R4 stride %0d", strides[s]), 1'b1);
        end
    endtask

    task automatic t_groups();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin a_act[l] = 1; a_addr[l] = (l < 8) ? 8'd5 : 8'd21; end
        run_access("R5 two groups one bank", 1'b1);
    endtask

    task automatic t_write_conflict();
        clear_lanes();
        a_act[3] = 1;  a_we[3] = 1;  a_addr[3] = 8'd40;  a_wd[3] = 32'h1111_0003;
        a_act[9] = 1;  a_we[9] = 1;  a_addr[9] = 8'd40;  a_wd[9] = 32'h2222_0009;
        a_act[14] = 1; a_we[14] = 1; a_addr[14] = 8'd40; a_wd[14] = 32'h3333_000E;
        run_access("R6 same-address writes", 1'b0);
        clear_lanes();
        a_act[0] = 1; a_addr[0] = 8'd40;
        run_access("R6 readback", 1'b0);
        chk(rd_data[DW-1:0] == 32'h3333_000E, "R6 highest lane wins", rd_data[DW-1:0], 32'h3333_000E);
    endtask

    task automatic t_inactive();
        logic [DW-1:0] keep;
        keep = ref_mem[50];
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin a_act[l] = (l != 2); a_addr[l] = AW'(96 + l); end
        a_we[2] = 1; a_addr[2] = 8'd50; a_wd[2] = 32'hDEAD_BEEF;
        run_access("R7 inactive lane", 1'b1);
        clear_lanes();
        for (int l = 0; l < 8; l++) begin a_addr[l] = AW'(16*l); a_we[l] = 1; a_wd[l] = 32'hBAD0_0000; end
        a_act[8] = 1; a_addr[8] = 8'd50;
        run_access("R7 inactive conflicts ignored", 1'b1);
        chk(rd_data[8*DW +: DW] == keep, "R7 no inactive write", rd_data[8*DW +: DW], keep);
    endtask

    task automatic t_empty();
        clear_lanes();
        run_access("R9 empty access", 1'b1);
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] keep;
        keep = ref_mem[60];
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin a_act[l] = 1; a_addr[l] = AW'(l * 8); end
        @(negedge clk);
        drive_req();
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            req_act[l] = 1; req_we[l] = 1; req_addr[l*AW +: AW] = 8'd60; req_wdata[l*DW +: DW] = 32'hFFFF_0000;
        end
        for (int c = 0; c < 3; c++) begin
            chk(ready == 1'b0, "R8 not ready while busy", 32'(ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int c = 0; c < 20 && !done; c++) @(negedge clk);
        chk(pass_cnt == 5'd8, "R8 busy access completes", 32'(pass_cnt), 8);
        @(negedge clk);
        chk(ready == 1'b1, "R8 back to idle", 32'(ready), 1);
        clear_lanes();
        a_act[0] = 1; a_addr[0] = 8'd60;
        run_access("R8 readback", 1'b0);
        chk(rd_data[DW-1:0] == keep, "R8 busy request ignored", rd_data[DW-1:0], keep);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_read();
        t_permute();
        t_broadcast();
        t_strides();
        t_groups();
        t_write_conflict();
        t_inactive();
        t_empty();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule